// File: doc/BRIEF.md
# Nested Trap Level Controller

This block tracks how deeply a processor is nested inside trap handlers and does the context bookkeeping on the way in and out. A trap request stores the interrupted program counter, next program counter, trap type and a trap-state record in the stack slot for the current level. The record holds the condition codes, address-space identifier, processor state and window pointer. The block then forces a privileged processor state, forms the handler address from a trap base input and steps the level up.

Two return commands pop one level. The "done" return resumes after the trapped instruction. The "retry" return re-executes it. Both restore the saved context fields. Results are registered and appear one cycle after the request as single-cycle pulses with their data. There is no back-pressure: the consumer must take a pulse in the cycle it is high. Data outputs hold their last value between pulses.

Top module: `trap_level_ctrl`

## Requirements
- R1: After reset the trap level is 0 and `redir_vld`, `restore_vld`, `trap_err` and `illegal_op` are low.
- R2: A trap taken at level L stores pc, npc, trap type and the context fields (ccr, asi, pstate, cwp) in slot L. Every later return from level L+1 reproduces exactly these values.
- R3: On a trap taken, `new_pstate` becomes 0x015, which sets alternate-globals (bit 0), privileged (bit 2) and FP-enable (bit 4) and clears all other bits. When the trap is taken at level MAXTL-1, the reduced-error bit (bit 5) is also set, giving 0x035.
- R4: On a trap taken, `redir_pc` equals `trap_base` with bits 14:0 replaced. Bit 14 is 1 only when the level before the trap is greater than 1, and bits 13:5 hold the trap type. `redir_npc` equals `redir_pc` + 4.
- R5: A taken trap raises the level by one, and `redir_vld` pulses in the cycle after the request. The level never exceeds MAXTL (default 5).
- R6: A trap requested at level MAXTL pulses `trap_err` for one cycle and changes nothing else: no redirect, same level, stack contents kept.
- R7: A done return sets `redir_pc` to the saved npc and `redir_npc` to the saved npc + 4.
- R8: A retry return sets `redir_pc` to the saved pc and `redir_npc` to the saved npc.
- R9: Both returns lower the level by one, pulse `restore_vld`, and drive `rest_ccr`, `rest_asi`, `new_pstate`, `rest_cwp` and `rest_tt` from the slot at the lowered level.
- R10: A done or retry at level 0 pulses `illegal_op` for one cycle and changes no state and no data output's meaning (no redirect, level stays 0).
- R11: When requests coincide, trap wins over done, and done wins over retry.
- R12: `redir_vld`, `trap_err` and `illegal_op` are one-cycle pulses and mutually exclusive. `restore_vld` is only ever high together with `redir_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap entry request strobe |
| trap_type | input | TT_W (9) | Trap type number |
| done_req | input | 1 | Return that skips the trapped instruction |
| retry_req | input | 1 | Return that re-executes the trapped instruction |
| cur_pc | input | PC_W (64) | Current program counter |
| cur_npc | input | PC_W (64) | Current next program counter |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pstate | input | 12 | Current processor state |
| cur_cwp | input | 8 | Current window pointer |
| trap_base | input | PC_W (64) | Trap base address; bits 14:0 are ignored |
| redir_vld | output | 1 | Pulse: new pc/npc valid |
| redir_pc | output | PC_W (64) | New program counter |
| redir_npc | output | PC_W (64) | New next program counter |
| new_pstate | output | 12 | Processor state after the event |
| restore_vld | output | 1 | Pulse: restored fields valid (returns only) |
| rest_ccr | output | 8 | Restored condition codes |
| rest_asi | output | 8 | Restored address-space identifier |
| rest_cwp | output | 8 | Restored window pointer |
| rest_tt | output | TT_W (9) | Trap type of the level being left |
| trap_level | output | TL_W (3) | Current trap level |
| trap_err | output | 1 | Pulse: trap refused at maximum level |
| illegal_op | output | 1 | Pulse: return refused at level 0 |

## Verification
Traps are taken at levels 0, 1 and 2, which separates the "level above one" vector bit from a plain level test. A trap base with all low bits set shows that those bits are cleared. An all-ones trap type is used next to a sparse one to expose a wrong shift or overlap with bit 14. Nesting runs to the maximum level and one trap beyond it, which separates the reduced-error entry from ordinary entries and checks that a refused trap leaves the stack intact. Unwinding alternates done and retry on slots whose npc is not pc + 4, so the two return flavours and slot indexing cannot be confused. Coincident strobes confirm the priority order.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  localparam int CCR_W = 8;
  localparam int ASI_W = 8;
  localparam int PST_W = 12;
  localparam int CWP_W = 8;

  localparam int PST_AG   = 0;
  localparam int PST_PRIV = 2;
  localparam int PST_PEF  = 4;
  localparam int PST_RED  = 5;

  typedef struct packed {
    logic [CCR_W-1:0] ccr;
    logic [ASI_W-1:0] asi;
    logic [PST_W-1:0] pst;
    logic [CWP_W-1:0] cwp;
  } tlc_tstate_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRAP,
    OP_TRAP_ERR,
    OP_DONE,
    OP_RETRY,
    OP_ILLEGAL
  } tlc_op_e;

endpackage

// File: rtl/tlc_decode.sv
module tlc_decode
  import tlc_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int TL_W  = 3
) (
  input  logic            trap_req,
  input  logic            done_req,
  input  logic            retry_req,
  input  logic [TL_W-1:0] tl_q,
  output tlc_op_e         op
);

  localparam logic [TL_W-1:0] TL_MAX  = TL_W'(MAXTL);
  localparam logic [TL_W-1:0] TL_ZERO = '0;

  always_comb begin
    op = OP_NONE;
    if (trap_req) begin
      op = (tl_q == TL_MAX) ? OP_TRAP_ERR : OP_TRAP;
    end else if (done_req || retry_req) begin
      if (tl_q == TL_ZERO) op = OP_ILLEGAL;
      else if (done_req)   op = OP_DONE;
      else                 op = OP_RETRY;
    end
  end

endmodule

// File: rtl/tlc_vector.sv
module tlc_vector
  import tlc_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int TL_W  = 3,
  parameter int PC_W  = 64,
  parameter int TT_W  = 9
) (
  input  logic [PC_W-1:0]  trap_base,
  input  logic [TT_W-1:0]  trap_type,
  input  logic [TL_W-1:0]  tl_q,
  output logic [PC_W-1:0]  vec_pc,
  output logic [PC_W-1:0]  vec_npc,
  output logic [PST_W-1:0] entry_pst
);

  localparam int LOW_W = 15;
  localparam logic [TL_W-1:0] TL_ONE  = TL_W'(1);
  localparam logic [TL_W-1:0] TL_EDGE = TL_W'(MAXTL - 1);

  logic [LOW_W-1:0] low;
  logic             above_one;

  assign above_one = (tl_q > TL_ONE);

  always_comb begin
    low = LOW_W'(trap_type) << 5;
    low[LOW_W-1] = above_one;
  end

  assign vec_pc  = {trap_base[PC_W-1:LOW_W], low};
  assign vec_npc = vec_pc + PC_W'(4);

  always_comb begin
    entry_pst = '0;
    entry_pst[PST_AG]   = 1'b1;
    entry_pst[PST_PRIV] = 1'b1;
    entry_pst[PST_PEF]  = 1'b1;
    entry_pst[PST_RED]  = (tl_q == TL_EDGE);
  end

endmodule

// File: rtl/tlc_stack.sv
module tlc_stack
  import tlc_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int IDX_W = 3,
  parameter int PC_W  = 64,
  parameter int TT_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [PC_W-1:0]  wpc,
  input  logic [PC_W-1:0]  wnpc,
  input  logic [TT_W-1:0]  wtt,
  input  tlc_tstate_t      wts,
  input  logic [IDX_W-1:0] ridx,
  output logic [PC_W-1:0]  rpc,
  output logic [PC_W-1:0]  rnpc,
  output logic [TT_W-1:0]  rtt,
  output tlc_tstate_t      rts
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [PC_W-1:0] pc_q  [DEPTH];
  logic [PC_W-1:0] npc_q [DEPTH];
  logic [TT_W-1:0] tt_q  [DEPTH];
  tlc_tstate_t     ts_q  [DEPTH];
  logic [DEPTH-1:0] hit;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_hit
      localparam logic [IDX_W-1:0] SID = IDX_W'(s);
      assign hit[s] = we && (widx == SID);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        pc_q[s]  <= '0;
        npc_q[s] <= '0;
        tt_q[s]  <= '0;
        ts_q[s]  <= '0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (hit[s]) begin
          pc_q[s]  <= wpc;
          npc_q[s] <= wnpc;
          tt_q[s]  <= wtt;
          ts_q[s]  <= wts;
        end
      end
    end
  end

  assign rpc  = (ridx <= LAST) ? pc_q[ridx]  : '0;
  assign rnpc = (ridx <= LAST) ? npc_q[ridx] : '0;
  assign rtt  = (ridx <= LAST) ? tt_q[ridx]  : '0;
  assign rts  = (ridx <= LAST) ? ts_q[ridx]  : '0;

endmodule

// File: rtl/trap_level_ctrl.sv
module trap_level_ctrl
  import tlc_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int PC_W  = 64,
  parameter int TT_W  = 9,
  parameter int TL_W  = $clog2(MAXTL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_req,
  input  logic [TT_W-1:0]  trap_type,
  input  logic             done_req,
  input  logic             retry_req,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [PC_W-1:0]  cur_npc,
  input  logic [7:0]       cur_ccr,
  input  logic [7:0]       cur_asi,
  input  logic [11:0]      cur_pstate,
  input  logic [7:0]       cur_cwp,
  input  logic [PC_W-1:0]  trap_base,
  output logic             redir_vld,
  output logic [PC_W-1:0]  redir_pc,
  output logic [PC_W-1:0]  redir_npc,
  output logic [11:0]      new_pstate,
  output logic             restore_vld,
  output logic [7:0]       rest_ccr,
  output logic [7:0]       rest_asi,
  output logic [7:0]       rest_cwp,
  output logic [TT_W-1:0]  rest_tt,
  output logic [TL_W-1:0]  trap_level,
  output logic             trap_err,
  output logic             illegal_op
);

  localparam logic [TL_W-1:0] TL_STEP = TL_W'(1);

  logic [TL_W-1:0]  tl_q;
  logic [TL_W-1:0]  rd_idx;
  tlc_op_e          op;
  logic [PC_W-1:0]  vec_pc, vec_npc;
  logic [PST_W-1:0] entry_pst;
  tlc_tstate_t      wr_ts, rd_ts;
  logic [PC_W-1:0]  rd_pc, rd_npc;
  logic [TT_W-1:0]  rd_tt;

  tlc_decode #(.MAXTL(MAXTL), .TL_W(TL_W)) u_decode (
    .trap_req  (trap_req),
    .done_req  (done_req),
    .retry_req (retry_req),
    .tl_q      (tl_q),
    .op        (op)
  );

  tlc_vector #(.MAXTL(MAXTL), .TL_W(TL_W), .PC_W(PC_W), .TT_W(TT_W)) u_vector (
    .trap_base (trap_base),
    .trap_type (trap_type),
    .tl_q      (tl_q),
    .vec_pc    (vec_pc),
    .vec_npc   (vec_npc),
    .entry_pst (entry_pst)
  );

  always_comb begin
    wr_ts.ccr = cur_ccr;
    wr_ts.asi = cur_asi;
    wr_ts.pst = cur_pstate;
    wr_ts.cwp = cur_cwp;
  end

  assign rd_idx = tl_q - TL_STEP;

  tlc_stack #(.DEPTH(MAXTL), .IDX_W(TL_W), .PC_W(PC_W), .TT_W(TT_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (op == OP_TRAP),
    .widx  (tl_q),
    .wpc   (cur_pc),
    .wnpc  (cur_npc),
    .wtt   (trap_type),
    .wts   (wr_ts),
    .ridx  (rd_idx),
    .rpc   (rd_pc),
    .rnpc  (rd_npc),
    .rtt   (rd_tt),
    .rts   (rd_ts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q        <= '0;
      redir_vld   <= 1'b0;
      restore_vld <= 1'b0;
      trap_err    <= 1'b0;
      illegal_op  <= 1'b0;
      redir_pc    <= '0;
      redir_npc   <= '0;
      new_pstate  <= '0;
      rest_ccr    <= '0;
      rest_asi    <= '0;
      rest_cwp    <= '0;
      rest_tt     <= '0;
    end else begin
      redir_vld   <= 1'b0;
      restore_vld <= 1'b0;
      trap_err    <= 1'b0;
      illegal_op  <= 1'b0;
      unique case (op)
        OP_TRAP: begin
          tl_q       <= tl_q + TL_STEP;
          redir_vld  <= 1'b1;
          redir_pc   <= vec_pc;
          redir_npc  <= vec_npc;
          new_pstate <= entry_pst;
        end
        OP_DONE, OP_RETRY: begin
          tl_q        <= rd_idx;
          redir_vld   <= 1'b1;
          restore_vld <= 1'b1;
          redir_pc    <= (op == OP_DONE) ? rd_npc : rd_pc;
          redir_npc   <= (op == OP_DONE) ? rd_npc + PC_W'(4) : rd_npc;
          new_pstate  <= rd_ts.pst;
          rest_ccr    <= rd_ts.ccr;
          rest_asi    <= rd_ts.asi;
          rest_cwp    <= rd_ts.cwp;
          rest_tt     <= rd_tt;
        end
        OP_TRAP_ERR: trap_err   <= 1'b1;
        OP_ILLEGAL:  illegal_op <= 1'b1;
        default: ;
      endcase
    end
  end

  assign trap_level = tl_q;

endmodule

// File: rtl/trap_level_ctrl_chk.sv
module trap_level_ctrl_chk #(
  parameter int MAXTL = 5,
  parameter int PC_W  = 64,
  parameter int TL_W  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            done_req,
  input logic            retry_req,
  input logic            redir_vld,
  input logic [PC_W-1:0] redir_pc,
  input logic [PC_W-1:0] redir_npc,
  input logic [11:0]     new_pstate,
  input logic            restore_vld,
  input logic [TL_W-1:0] trap_level,
  input logic            trap_err,
  input logic            illegal_op
);

  localparam logic [TL_W-1:0] TL_MAX = TL_W'(MAXTL);
  localparam logic [TL_W-1:0] TL_ONE = TL_W'(1);

  logic take_trap, full_trap, any_ret;
  assign take_trap = trap_req && (trap_level != TL_MAX);
  assign full_trap = trap_req && (trap_level == TL_MAX);
  assign any_ret   = !trap_req && (done_req || retry_req);

  AST_TL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_level <= TL_MAX); // R5
  AST_TRAP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> redir_vld && (trap_level == $past(trap_level) + TL_ONE)); // R5
  AST_TRAP_PST: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> new_pstate[0] && new_pstate[2] && new_pstate[4]); // R3
  AST_TRAP_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> redir_npc == redir_pc + PC_W'(4)); // R4
  AST_FULL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    full_trap |=> trap_err && !redir_vld && (trap_level == TL_MAX)); // R6
  AST_RET_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ret && trap_level != '0) |=> restore_vld && (trap_level == $past(trap_level) - TL_ONE)); // R9
  AST_DONE_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && done_req && trap_level != '0) |=> redir_npc == redir_pc + PC_W'(4)); // R7
  AST_EMPTY_ILL: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ret && trap_level == '0) |=> illegal_op && !redir_vld && (trap_level == '0)); // R10
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redir_vld, trap_err, illegal_op})); // R12
  AST_RESTORE_SUB: assert property (@(posedge clk) disable iff (!rst_n)
    restore_vld |-> redir_vld); // R12

endmodule

bind trap_level_ctrl trap_level_ctrl_chk #(.MAXTL(MAXTL), .PC_W(PC_W), .TL_W(TL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trap_req    (trap_req),
  .done_req    (done_req),
  .retry_req   (retry_req),
  .redir_vld   (redir_vld),
  .redir_pc    (redir_pc),
  .redir_npc   (redir_npc),
  .new_pstate  (new_pstate),
  .restore_vld (restore_vld),
  .trap_level  (trap_level),
  .trap_err    (trap_err),
  .illegal_op  (illegal_op)
);

// File: tb/trap_level_ctrl_tb.sv
module trap_level_ctrl_tb;

  localparam int MAXTL = 5;
  localparam int PC_W  = 64;
  localparam int TT_W  = 9;
  localparam int TL_W  = $clog2(MAXTL + 1);
  localparam logic [63:0] TBASE = 64'h1234_5678_9ABC_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0, done_req = 1'b0, retry_req = 1'b0;
  logic [TT_W-1:0] trap_type = '0;
  logic [PC_W-1:0] cur_pc = '0, cur_npc = '0;
  logic [7:0]  cur_ccr = '0, cur_asi = '0, cur_cwp = '0;
  logic [11:0] cur_pstate = '0;
  logic [PC_W-1:0] trap_base = TBASE;
  logic redir_vld, restore_vld, trap_err, illegal_op;
  logic [PC_W-1:0] redir_pc, redir_npc;
  logic [11:0] new_pstate;
  logic [7:0]  rest_ccr, rest_asi, rest_cwp;
  logic [TT_W-1:0] rest_tt;
  logic [TL_W-1:0] trap_level;

  trap_level_ctrl #(.MAXTL(MAXTL), .PC_W(PC_W), .TT_W(TT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_type(trap_type),
    .done_req(done_req), .retry_req(retry_req), .cur_pc(cur_pc), .cur_npc(cur_npc),
    .cur_ccr(cur_ccr), .cur_asi(cur_asi), .cur_pstate(cur_pstate), .cur_cwp(cur_cwp),
    .trap_base(trap_base), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .redir_npc(redir_npc), .new_pstate(new_pstate), .restore_vld(restore_vld),
    .rest_ccr(rest_ccr), .rest_asi(rest_asi), .rest_cwp(rest_cwp), .rest_tt(rest_tt),
    .trap_level(trap_level), .trap_err(trap_err), .illegal_op(illegal_op)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [63:0] m_pc [MAXTL];
  logic [63:0] m_npc [MAXTL];
  logic [8:0]  m_tt [MAXTL];
  logic [7:0]  m_ccr [MAXTL];
  logic [7:0]  m_asi [MAXTL];
  logic [11:0] m_pst [MAXTL];
  logic [7:0]  m_cwp [MAXTL];
  int m_tl = 0;

  task automatic ceq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    trap_req = 1'b0; done_req = 1'b0; retry_req = 1'b0;
  endtask

  // trap entry with optional coincident return strobes
  task automatic do_trap(input logic [8:0] tt, input logic [63:0] pc, input logic [63:0] npc,
                         input logic [7:0] ccr, input logic [7:0] asi, input logic [11:0] pst,
                         input logic [7:0] cwp, input bit xdone, input bit xretry);
    logic [63:0] exp_pc;
    logic [11:0] exp_pst;
    trap_type = tt; cur_pc = pc; cur_npc = npc; cur_ccr = ccr; cur_asi = asi;
    cur_pstate = pst; cur_cwp = cwp;
    trap_req = 1'b1; done_req = xdone; retry_req = xretry;
    exp_pc = (TBASE & ~64'h7FFF) | ((m_tl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
    exp_pst = 12'h015 | ((m_tl == MAXTL - 1) ? 12'h020 : 12'h000);
    m_pc[m_tl] = pc; m_npc[m_tl] = npc; m_tt[m_tl] = tt; m_ccr[m_tl] = ccr;
    m_asi[m_tl] = asi; m_pst[m_tl] = pst; m_cwp[m_tl] = cwp;
    m_tl++;
    step();
    clear_in();
    ceq("R5 redir_vld", 64'(redir_vld), 64'd1);
    ceq("R4 vector pc", redir_pc, exp_pc);
    ceq("R4 vector npc", redir_npc, exp_pc + 64'd4);
    ceq("R3 entry pstate", 64'(new_pstate), 64'(exp_pst));
    ceq("R5 level up", 64'(trap_level), 64'(m_tl));
    ceq("R12 no restore on trap", 64'(restore_vld), 64'd0);
  endtask

  // return; is_done selects flavour, both=1 drives both strobes (R11)
  task automatic do_ret(input bit is_done, input bit both);
    done_req = is_done | both; retry_req = ~is_done | both;
    m_tl--;
    step();
    clear_in();
    ceq("R9 restore_vld", 64'(restore_vld), 64'd1);
    ceq("R9 level down", 64'(trap_level), 64'(m_tl));
    if (is_done) begin
      ceq("R7 done pc", redir_pc, m_npc[m_tl]);
      ceq("R7 done npc", redir_npc, m_npc[m_tl] + 64'd4);
    end else begin
      ceq("R8 retry pc", redir_pc, m_pc[m_tl]);
      ceq("R8 retry npc", redir_npc, m_npc[m_tl]);
    end
    ceq("R9 pstate", 64'(new_pstate), 64'(m_pst[m_tl]));
    ceq("R9 ccr", 64'(rest_ccr), 64'(m_ccr[m_tl]));
    ceq("R9 asi", 64'(rest_asi), 64'(m_asi[m_tl]));
    ceq("R9 cwp", 64'(rest_cwp), 64'(m_cwp[m_tl]));
    ceq("R2 saved tt", 64'(rest_tt), 64'(m_tt[m_tl]));
  endtask

  task automatic t_reset_state();
    ceq("R1 level", 64'(trap_level), 64'd0);
    ceq("R1 redir_vld", 64'(redir_vld), 64'd0);
    ceq("R1 restore_vld", 64'(restore_vld), 64'd0);
    ceq("R1 trap_err", 64'(trap_err), 64'd0);
    ceq("R1 illegal_op", 64'(illegal_op), 64'd0);
  endtask

  task automatic t_nest_to_full();
    do_trap(9'h1FF, 64'h1000, 64'h2000, 8'hA1, 8'h80, 12'h004, 8'h01, 1'b0, 1'b0);
    do_trap(9'h041, 64'h1100, 64'h1200, 8'hB2, 8'h81, 12'h015, 8'h02, 1'b0, 1'b0);
    do_trap(9'h001, 64'h2300, 64'h3300, 8'hC3, 8'h82, 12'h017, 8'h03, 1'b0, 1'b0);
    do_trap(9'h100, 64'h4400, 64'h5500, 8'hD4, 8'h83, 12'h415, 8'h04, 1'b0, 1'b0);
    do_trap(9'h0AA, 64'h6600, 64'h7700, 8'hE5, 8'h84, 12'h815, 8'h05, 1'b0, 1'b0);
  endtask

  task automatic t_full_error();
    trap_type = 9'h033; cur_pc = 64'hDEAD; cur_npc = 64'hBEEF; trap_req = 1'b1;
    step();
    clear_in();
    ceq("R6 trap_err pulse", 64'(trap_err), 64'd1);
    ceq("R6 no redirect", 64'(redir_vld), 64'd0);
    ceq("R6 level kept", 64'(trap_level), 64'(MAXTL));
    step();
    ceq("R12 trap_err one cycle", 64'(trap_err), 64'd0);
  endtask

  task automatic t_unwind();
    do_ret(1'b0, 1'b0);
    do_ret(1'b1, 1'b0);
    do_ret(1'b0, 1'b0);
    do_ret(1'b1, 1'b0);
    do_ret(1'b0, 1'b0);
  endtask

  task automatic t_empty_illegal();
    done_req = 1'b1;
    step();
    clear_in();
    ceq("R10 illegal_op done", 64'(illegal_op), 64'd1);
    ceq("R10 no redirect", 64'(redir_vld), 64'd0);
    ceq("R10 level kept", 64'(trap_level), 64'd0);
    retry_req = 1'b1;
    step();
    clear_in();
    ceq("R10 illegal_op retry", 64'(illegal_op), 64'd1);
    ceq("R10 no restore", 64'(restore_vld), 64'd0);
  endtask

  task automatic t_priority();
    do_trap(9'h077, 64'h9000, 64'h9010, 8'h11, 8'h22, 12'h333, 8'h44, 1'b1, 1'b1); // R11 trap wins
    do_ret(1'b1, 1'b1); // R11 done wins over retry
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_empty_illegal();
    t_nest_to_full();
    t_full_error();
    t_unwind();
    t_empty_illegal();
    t_priority();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule